// File: doc/BRIEF.md
# Reset Control Register

A one-byte register in I/O space through which software can ask for a system reset or note which kind of reset it prefers. The register answers at a single address that is set by a parameter. A write that has the request bit (bit 2) set produces a one-clock reset-request pulse for the reset sequencer outside the block. Such a write leaves the stored byte as it was. Any other write keeps only the reset-type bit (bit 1) and clears every other bit of the byte.

A selected read returns the stored byte on the same cycle. When the port is not selected for a read, the read bus stays at zero. A status output is high whenever the stored byte is nonzero, so that state-preservation logic knows the register holds something worth saving.

Top module: `rst_ctl_reg`

## Requirements
- R1: A write to the port with bit 2 of the data set, made while the request output is low, drives the request output high in the cycle after the write and low again one cycle after that.
- R2: A write with bit 2 set leaves the stored byte unchanged.
- R3: A write to the port with bit 2 clear stores the byte with bit 1 equal to bit 1 of the written data and all other bits zero.
- R4: A read with the address matching returns the stored byte combinationally; in any other cycle the read data is zero.
- R5: A synchronous active-low reset clears the stored byte and the request output.
- R6: A request write made while the request output is high produces no second pulse and does not change the stored byte.
- R7: Writes to any other address change neither the stored byte nor the request output.
- R8: The status output is high exactly when the stored byte is nonzero.
- R9: A read and a write to the port in the same cycle return the byte as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not selected |
| sys_rst_req | output | 1 | Reset request pulse, one clock long |
| keep_state | output | 1 | High when the stored byte is nonzero |

## Verification
Two events can fall in the same cycle. The first is a request write while the previous pulse is still high. The second is a read and a write to the port together. The bench provokes the first with two back-to-back writes of 0xFF and the second by asserting both strobes in one cycle. A behavioural model predicts each cycle's result. It expects exactly one pulse and no change to the stored byte in the first case, and the pre-write byte on the read bus in the second.

// File: rtl/rst_ctl_pkg.sv
// Shared constants for the reset control register: data width and the
// positions of the two meaningful bits. Assumes a byte-wide data bus.
package rst_ctl_pkg;
    parameter int DATA_W   = 8;
    parameter int REQ_BIT  = 2;   // write-only: asks for a reset
    parameter int TYPE_BIT = 1;   // kept: preferred reset type
    localparam logic [DATA_W-1:0] TYPE_MASK = DATA_W'(1) << TYPE_BIT;
endpackage

// File: rtl/rst_ctl_decode.sv
// Address decode and strobe split for the reset control register.
// Turns a matching write into either a request strobe or a store strobe,
// and flags a matching read. Assumes strobes last exactly one cycle.
module rst_ctl_decode
    import rst_ctl_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00F0
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              req_bit,
    output logic              req_stb,
    output logic              store_stb,
    output logic              rd_sel
);
    logic hit;

    // Decide which action this cycle's access asks for.
    always_comb begin
        hit       = (io_addr == PORT_ADDR);
        req_stb   = hit && io_wr && req_bit;
        store_stb = hit && io_wr && !req_bit;
        rd_sel    = hit && io_rd;
    end
endmodule

// File: rtl/rst_ctl_pulse.sv
// One-clock reset request generator. A request strobe while the output
// is low raises it for one cycle; strobes while it is high are dropped.
module rst_ctl_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic req_stb,
    output logic pulse
);
    // Register the pulse; it never stays high two cycles in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= req_stb && !pulse;
    end

    assert_pulse_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stb && !pulse) |=> pulse);
    assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/rst_ctl_store.sv
// Storage for the reset control byte. Loads the masked write data on a
// store strobe and holds otherwise. Assumes strobes come from the decoder.
module rst_ctl_store
    import rst_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_stb,
    input  logic              req_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stored,
    output logic              nonzero
);
    // Keep only the reset-type bit of a storing write.
    always_ff @(posedge clk) begin
        if (!rst_n)         stored <= '0;
        else if (store_stb) stored <= wdata & TYPE_MASK;
    end

    // Tell state-save logic the byte needs preserving.
    always_comb nonzero = |stored;

    assert_hold_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_stb |=> $stable(stored));
    assert_type_bit_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        store_stb |=> (stored[TYPE_BIT] == $past(wdata[TYPE_BIT]))
                      && ($countones(stored) == (stored[TYPE_BIT] ? 1 : 0)));
endmodule

// File: rtl/rst_ctl_reg.sv
// Reset control register top. A one-byte I/O port: request writes pulse
// sys_rst_req, other writes keep the reset-type bit, reads return the byte.
// Assumes one access strobe per cycle per direction and a synchronous reset.
module rst_ctl_reg
    import rst_ctl_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              sys_rst_req,
    output logic              keep_state
);
    logic              req_stb, store_stb, rd_sel;
    logic [DATA_W-1:0] stored;

    rst_ctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .req_bit   (io_wdata[REQ_BIT]),
        .req_stb   (req_stb),
        .store_stb (store_stb),
        .rd_sel    (rd_sel)
    );

    rst_ctl_pulse u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_stb (req_stb),
        .pulse   (sys_rst_req)
    );

    rst_ctl_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_stb (store_stb),
        .req_stb   (req_stb),
        .wdata     (io_wdata),
        .stored    (stored),
        .nonzero   (keep_state)
    );

    // Drive the read bus only for a selected read.
    always_comb io_rdata = rd_sel ? stored : '0;

    assert_foreign_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr != PORT_ADDR) |=> $stable(stored));
    assert_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == 8'h00);
    assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (store_stb && !io_wdata[TYPE_BIT]) |=> !keep_state);
endmodule

// File: tb/tb_rst_ctl_reg.sv
`timescale 1ns/1ps
// Bench: behavioural model of the byte and the pulse, compared each cycle.
module tb_rst_ctl_reg;
    localparam logic [15:0] PORT = 16'h00F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        sys_rst_req, keep_state;

    int checks = 0, fails = 0;
    bit done = 0;
    int m_byte = 0;
    int m_pulse = 0;
    int pulses_seen = 0;

    always #2 clk = ~clk;

    rst_ctl_reg #(.ADDR_W(16), .PORT_ADDR(PORT)) dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .sys_rst_req(sys_rst_req), .keep_state(keep_state)
    );

    task automatic cmp(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before the edge, advance model.
    task automatic step(string tag, logic rn, logic [15:0] a, logic w, logic r,
                        logic [7:0] d);
        int exp_rd;
        rst_n = rn; io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
        #1;
        exp_rd = (r && a == PORT) ? m_byte : 0;
        cmp({tag, " rdata (R4/R9)"}, io_rdata, exp_rd);
        cmp({tag, " request (R1/R6)"}, sys_rst_req, m_pulse);
        cmp({tag, " status R8"}, keep_state, (m_byte != 0) ? 1 : 0);
        if (sys_rst_req) pulses_seen++;
        @(posedge clk);
        if (!rn) begin
            m_byte = 0; m_pulse = 0;
        end else begin
            int np;
            np = (a == PORT && w && d[2] && m_pulse == 0) ? 1 : 0;
            if (a == PORT && w && !d[2]) m_byte = d & 8'h02;
            m_pulse = np;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R5: reset state
        repeat (3) step("R5", 1'b0, PORT, 1'b0, 1'b1, 8'h00);
        step("R5 idle", 1'b1, PORT, 1'b0, 1'b1, 8'h00);
        cmp("R5 byte after reset", io_rdata, 0);
        // R1 and R2: request write, byte stays zero
        step("R1", 1'b1, PORT, 1'b1, 1'b0, 8'hFF);
        cmp("R1 pulse high next cycle", sys_rst_req, 1);
        step("R1 fall", 1'b1, PORT, 1'b0, 1'b1, 8'h00);
        cmp("R1 pulse low after one cycle", sys_rst_req, 0);
        cmp("R2 byte unchanged", io_rdata, 0);
        // R3: store keeps bit 1 only
        step("R3", 1'b1, PORT, 1'b1, 1'b0, 8'hFB);
        step("R3 rd", 1'b1, PORT, 1'b0, 1'b1, 8'h00);
        cmp("R3 stored 0x02", io_rdata, 8'h02);
        // R2 with nonzero byte
        step("R2", 1'b1, PORT, 1'b1, 1'b0, 8'h04);
        step("R2 rd", 1'b1, PORT, 1'b0, 1'b1, 8'h00);
        cmp("R2 byte still 0x02", io_rdata, 8'h02);
        // R6: back-to-back requests give one pulse
        pulses_seen = 0;
        step("R6 a", 1'b1, PORT, 1'b1, 1'b0, 8'hFF);
        step("R6 b", 1'b1, PORT, 1'b1, 1'b0, 8'hFF);
        step("R6 c", 1'b1, PORT, 1'b0, 1'b1, 8'h00);
        step("R6 d", 1'b1, PORT, 1'b0, 1'b0, 8'h00);
        cmp("R6 single pulse", pulses_seen, 1);
        // R7: foreign address write and read
        step("R7", 1'b1, PORT + 16'h1, 1'b1, 1'b0, 8'h00);
        step("R7 req", 1'b1, PORT - 16'h1, 1'b1, 1'b0, 8'h04);
        cmp("R7 no pulse", sys_rst_req, 0);
        step("R7 rd", 1'b1, PORT, 1'b0, 1'b1, 8'h00);
        cmp("R7 byte kept", io_rdata, 8'h02);
        step("R4 foreign rd", 1'b1, PORT + 16'h1, 1'b0, 1'b1, 8'h00);
        cmp("R4 unselected zero", io_rdata, 0);
        // R9: read during write returns old value
        step("R9", 1'b1, PORT, 1'b1, 1'b1, 8'h00);
        step("R9 rd", 1'b1, PORT, 1'b0, 1'b1, 8'h00);
        cmp("R9 new byte visible after", io_rdata, 0);
        // R3/R8 sweep over all write values
        for (int v = 0; v < 256; v++) begin
            step("R3 sweep", 1'b1, PORT, 1'b1, 1'b1, v[7:0]);
            step("R8 sweep", 1'b1, PORT, 1'b0, 1'b1, 8'h00);
        end
        // R5: reset with nonzero byte
        step("R5 set", 1'b1, PORT, 1'b1, 1'b0, 8'h02);
        step("R5 req", 1'b1, PORT, 1'b1, 1'b0, 8'h04);
        step("R5 mid", 1'b0, PORT, 1'b0, 1'b1, 8'h00);
        step("R5 after", 1'b1, PORT, 1'b0, 1'b1, 8'h00);
        cmp("R5 cleared", io_rdata, 0);
        cmp("R5 request low", sys_rst_req, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule